// File: doc/BRIEF.md
# Write Response Ordering Tracker

This block watches the write address, write data and write response channels of one AXI4 interface. It checks that every write response belongs to the oldest outstanding write and arrives only after that write's final data beat. All transactions are assumed in order, with no interleaving. The tracker keeps a fixed ring of slots rather than a searchable table. Each accepted write address claims the next slot and stores its ID. The data channel's final beats are assigned to slots in the same order. A response is compared against the slot at the head of the ring, and that slot is then freed.

Each slot is a small state machine with four states:
- `SLOT_FREE`: the slot holds nothing.
- `SLOT_ADDR`: the address is stored and the final beat is still awaited.
- `SLOT_EARLY`: the final beat arrived before its address.
- `SLOT_READY`: both the address and the final beat are present.

The slot moves between these states on four events:
- claim: an address is stored into the slot.
- finish: the final data beat is assigned to the slot.
- retire: the response is consumed from the slot.
- reuse: the slot is retired and claimed again in the same cycle.

The ring itself is a second state machine with the states `RING_EMPTY`, `RING_PARTIAL` and `RING_FULL`. It changes state on fill (the last free slot is taken), drain (the last active slot is retired), leave-empty and leave-full.

Each active slot carries an age counter, so a write that stalls raises a timeout. An address accepted while the ring is full raises an overflow. A response seen while nothing is outstanding is flagged as unexpected. Every error is a one-cycle pulse. The block also reports its occupancy, an empty indication, and running counts of writes pushed and writes retired, so that forward progress can be observed.

Top module: `wresp_order_tracker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `occupancy`, `pushed_cnt`, `retired_cnt` and all five error outputs are 0 and `empty` is 1.
- R2: An address handshake (`aw_valid && aw_ready`) that is accepted stores `aw_id` in the next slot. `occupancy` and `pushed_cnt` rise by one in the cycle after that edge. A valid without ready has no effect.
- R3: A response handshake (`b_valid && b_ready`) while at least one slot is active compares `b_id` with the oldest stored ID. A mismatch pulses `err_id_mismatch` for one cycle, in the cycle after the handshake.
- R4: Final data beats (`w_valid && w_ready && w_last`) are assigned to writes in address order, and a final beat may precede its address. A response whose oldest write has not yet received its final beat pulses `err_early_resp` in the cycle after the handshake. A final beat in the same cycle as the response counts as too late.
- R5: If a slot is still active TIMEOUT clock edges after the edge that stored it, `err_timeout` pulses for one cycle, in the cycle after that edge. With TIMEOUT_EN=0 it never rises.
- R6: An address handshake while all SLOTS slots are active, with no response retiring in the same cycle, is dropped (occupancy and `pushed_cnt` unchanged). It pulses `err_overflow` in the next cycle. With OVERFLOW_EN=0 the write is still dropped but the flag stays 0.
- R7: A response handshake while no slot is active pulses `err_unexpected` in the next cycle and changes no other output.
- R8: An address handshake and a retiring response in the same cycle leave `occupancy` unchanged, even when the ring is full, and raise no overflow.
- R9: `retired_cnt` rises by one for each response that finds an active slot. `empty` is 1 exactly when `occupancy` is 0.
- R10: After a retirement, the next response is compared against the next-oldest stored ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address transaction ID |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_last | input | 1 | Final beat of a write burst |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | ID_W | Write response transaction ID |
| err_id_mismatch | output | 1 | Response ID differs from the oldest write |
| err_early_resp | output | 1 | Response arrived before the final data beat |
| err_timeout | output | 1 | A write stayed outstanding for TIMEOUT cycles |
| err_overflow | output | 1 | Address accepted while all slots were active |
| err_unexpected | output | 1 | Response with no write outstanding |
| occupancy | output | $clog2(SLOTS+1) | Number of active slots |
| empty | output | 1 | No slot is active |
| pushed_cnt | output | CNT_W | Writes stored since reset (wraps) |
| retired_cnt | output | CNT_W | Writes retired since reset (wraps) |

## Verification
Every output except the timeout is a register loaded on the edge at which its handshake is sampled. Occupancy, the counters and the response, overflow and unexpected flags therefore show the result in the cycle after that edge. A timeout appears in the cycle after the TIMEOUT-th edge following the edge that stored the write. The bench drives each input set just after a falling edge and steps a queue-based model at once. It waits for the next rising edge and compares every output at the following falling edge, so each result is read exactly one register stage after its cause. A second instance with both optional checks disabled is compared in the same cycles.

// File: rtl/wrt_pkg.sv
package wrt_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_ADDR  = 2'd1,
        SLOT_EARLY = 2'd2,
        SLOT_READY = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        RING_EMPTY   = 2'd0,
        RING_PARTIAL = 2'd1,
        RING_FULL    = 2'd2
    } ring_state_e;

    function automatic logic slot_active(input slot_state_e s);
        return (s == SLOT_ADDR) || (s == SLOT_READY);
    endfunction

endpackage

// File: rtl/wrt_slot.sv
module wrt_slot
    import wrt_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int TIMEOUT = 16,
    localparam int AGE_W  = $clog2(TIMEOUT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            last_i,
    input  logic            pop_i,
    output slot_state_e     state_o,
    output logic [ID_W-1:0] id_o,
    output logic            hit_o
);

    slot_state_e       state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [AGE_W-1:0]  age_q;
    logic              active;

    assign active = slot_active(state_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // transitions: claim, finish, retire, reuse
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (push_i)      state_d = last_i ? SLOT_READY : SLOT_ADDR;
                else if (last_i) state_d = SLOT_EARLY;
            end
            SLOT_ADDR: begin
                if (pop_i)       state_d = push_i ? (last_i ? SLOT_READY : SLOT_ADDR) : SLOT_FREE;
                else if (last_i) state_d = SLOT_READY;
            end
            SLOT_EARLY: begin
                if (push_i)      state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (pop_i) begin
                    if (push_i)  state_d = last_i ? SLOT_READY : SLOT_ADDR;
                    else         state_d = last_i ? SLOT_EARLY : SLOT_FREE;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // payload and age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            age_q <= '0;
        end else if (push_i) begin
            id_q  <= id_i;
            age_q <= '0;
        end else if (active && age_q != AGE_W'(TIMEOUT)) begin
            age_q <= age_q + AGE_W'(1);
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        id_o    = id_q;
        hit_o   = active && !pop_i && (age_q == AGE_W'(TIMEOUT - 1));
    end

endmodule

// File: rtl/wrt_ring.sv
module wrt_ring
    import wrt_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 16,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int OCC_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_hs,
    input  logic             wlast_hs,
    input  logic             b_hs,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic [PTR_W-1:0] dptr_o,
    output logic [OCC_W-1:0] occ_o,
    output logic             empty_o,
    output logic             push_ok_o,
    output logic             retire_o,
    output logic             overflow_ev_o,
    output logic             unexpected_ev_o,
    output logic [CNT_W-1:0] pushed_o,
    output logic [CNT_W-1:0] retired_o
);

    ring_state_e      state_q, state_d;
    logic [PTR_W-1:0] head_q, tail_q, dptr_q;
    logic [OCC_W-1:0] occ_q;
    logic [CNT_W-1:0] pushed_q, retired_q;
    logic             push_ok, retire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign retire  = b_hs && (state_q != RING_EMPTY);
    assign push_ok = aw_hs && ((state_q != RING_FULL) || retire);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RING_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: fill, drain, leave-empty, leave-full
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RING_EMPTY: begin
                if (push_ok) state_d = (SLOTS == 1) ? RING_FULL : RING_PARTIAL;
            end
            RING_PARTIAL: begin
                if (push_ok && !retire && occ_q == OCC_W'(SLOTS - 1))
                    state_d = RING_FULL;
                else if (retire && !push_ok && occ_q == OCC_W'(1))
                    state_d = RING_EMPTY;
            end
            RING_FULL: begin
                if (retire && !push_ok)
                    state_d = (SLOTS == 1) ? RING_EMPTY : RING_PARTIAL;
            end
            default: state_d = RING_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            dptr_q    <= '0;
            occ_q     <= '0;
            pushed_q  <= '0;
            retired_q <= '0;
        end else begin
            if (push_ok)  tail_q <= bump(tail_q);
            if (retire)   head_q <= bump(head_q);
            if (wlast_hs) dptr_q <= bump(dptr_q);
            unique case ({push_ok, retire})
                2'b10:   occ_q <= occ_q + OCC_W'(1);
                2'b01:   occ_q <= occ_q - OCC_W'(1);
                default: occ_q <= occ_q;
            endcase
            if (push_ok) pushed_q  <= pushed_q + CNT_W'(1);
            if (retire)  retired_q <= retired_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        head_o          = head_q;
        tail_o          = tail_q;
        dptr_o          = dptr_q;
        occ_o           = occ_q;
        empty_o         = (state_q == RING_EMPTY);
        push_ok_o       = push_ok;
        retire_o        = retire;
        overflow_ev_o   = aw_hs && !push_ok;
        unexpected_ev_o = b_hs && (state_q == RING_EMPTY);
        pushed_o        = pushed_q;
        retired_o       = retired_q;
    end

endmodule

// File: rtl/wrt_errors.sv
module wrt_errors
    import wrt_pkg::*;
#(
    parameter int ID_W        = 4,
    parameter int SLOTS       = 4,
    parameter bit TIMEOUT_EN  = 1'b1,
    parameter bit OVERFLOW_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic [ID_W-1:0]  b_id_i,
    input  logic [ID_W-1:0]  head_id_i,
    input  slot_state_e      head_state_i,
    input  logic [SLOTS-1:0] hit_i,
    input  logic             overflow_ev_i,
    input  logic             unexpected_ev_i,
    output logic             err_id_mismatch_o,
    output logic             err_early_resp_o,
    output logic             err_timeout_o,
    output logic             err_overflow_o,
    output logic             err_unexpected_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_id_mismatch_o <= 1'b0;
            err_early_resp_o  <= 1'b0;
            err_timeout_o     <= 1'b0;
            err_overflow_o    <= 1'b0;
            err_unexpected_o  <= 1'b0;
        end else begin
            err_id_mismatch_o <= retire_i && (b_id_i != head_id_i);
            err_early_resp_o  <= retire_i && (head_state_i != SLOT_READY);
            err_timeout_o     <= TIMEOUT_EN && (|hit_i);
            err_overflow_o    <= OVERFLOW_EN && overflow_ev_i;
            err_unexpected_o  <= unexpected_ev_i;
        end
    end

endmodule

// File: rtl/wresp_order_tracker.sv
module wresp_order_tracker
    import wrt_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int ID_W        = 4,
    parameter int TIMEOUT     = 16,
    parameter bit TIMEOUT_EN  = 1'b1,
    parameter bit OVERFLOW_EN = 1'b1,
    parameter int CNT_W       = 16,
    localparam int OCC_W      = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aw_valid,
    input  logic             aw_ready,
    input  logic [ID_W-1:0]  aw_id,
    input  logic             w_valid,
    input  logic             w_ready,
    input  logic             w_last,
    input  logic             b_valid,
    input  logic             b_ready,
    input  logic [ID_W-1:0]  b_id,
    output logic             err_id_mismatch,
    output logic             err_early_resp,
    output logic             err_timeout,
    output logic             err_overflow,
    output logic             err_unexpected,
    output logic [OCC_W-1:0] occupancy,
    output logic             empty,
    output logic [CNT_W-1:0] pushed_cnt,
    output logic [CNT_W-1:0] retired_cnt
);

    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic             aw_hs, wlast_hs, b_hs;
    logic [PTR_W-1:0] head, tail, dptr;
    logic             push_ok, retire, overflow_ev, unexpected_ev;
    logic [ID_W-1:0]  slot_id [SLOTS];
    slot_state_e      slot_st [SLOTS];
    logic [SLOTS-1:0] hit;

    assign aw_hs    = aw_valid && aw_ready;
    assign wlast_hs = w_valid && w_ready && w_last;
    assign b_hs     = b_valid && b_ready;

    wrt_ring #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) ring_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .aw_hs           (aw_hs),
        .wlast_hs        (wlast_hs),
        .b_hs            (b_hs),
        .head_o          (head),
        .tail_o          (tail),
        .dptr_o          (dptr),
        .occ_o           (occupancy),
        .empty_o         (empty),
        .push_ok_o       (push_ok),
        .retire_o        (retire),
        .overflow_ev_o   (overflow_ev),
        .unexpected_ev_o (unexpected_ev),
        .pushed_o        (pushed_cnt),
        .retired_o       (retired_cnt)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        wrt_slot #(
            .ID_W    (ID_W),
            .TIMEOUT (TIMEOUT)
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push_ok && (tail == PTR_W'(g))),
            .id_i    (aw_id),
            .last_i  (wlast_hs && (dptr == PTR_W'(g))),
            .pop_i   (retire && (head == PTR_W'(g))),
            .state_o (slot_st[g]),
            .id_o    (slot_id[g]),
            .hit_o   (hit[g])
        );
    end

    wrt_errors #(
        .ID_W        (ID_W),
        .SLOTS       (SLOTS),
        .TIMEOUT_EN  (TIMEOUT_EN),
        .OVERFLOW_EN (OVERFLOW_EN)
    ) err_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .retire_i          (retire),
        .b_id_i            (b_id),
        .head_id_i         (slot_id[head]),
        .head_state_i      (slot_st[head]),
        .hit_i             (hit),
        .overflow_ev_i     (overflow_ev),
        .unexpected_ev_i   (unexpected_ev),
        .err_id_mismatch_o (err_id_mismatch),
        .err_early_resp_o  (err_early_resp),
        .err_timeout_o     (err_timeout),
        .err_overflow_o    (err_overflow),
        .err_unexpected_o  (err_unexpected)
    );

endmodule

// File: rtl/wresp_order_tracker_sva.sv
module wresp_order_tracker_sva #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 16,
    localparam int OCC_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             aw_valid,
    input logic             aw_ready,
    input logic             b_valid,
    input logic             b_ready,
    input logic             err_id_mismatch,
    input logic             err_timeout,
    input logic             err_unexpected,
    input logic [OCC_W-1:0] occupancy,
    input logic             empty,
    input logic [CNT_W-1:0] retired_cnt
);

    // R2: occupancy moves only after a handshake
    a_r2_occ_needs_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy != $past(occupancy)) |-> $past((aw_valid && aw_ready) || (b_valid && b_ready)));

    // R3: a mismatch follows a response that found an active slot
    a_r3_mismatch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_id_mismatch |-> $past(b_valid && b_ready && !empty));

    // R5: a timeout needs an outstanding write
    a_r5_timeout_active: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !$past(empty));

    // R6: occupancy never exceeds capacity
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= OCC_W'(SLOTS));

    // R7: unexpected response only from the empty ring
    a_r7_unexpected_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_unexpected |-> $past(b_valid && b_ready && empty));

    // R8: simultaneous store and retire keep occupancy
    a_r8_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && b_valid && b_ready && !empty) |=> $stable(occupancy));

    // R9: retirement count moves only on a response
    a_r9_retire_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (retired_cnt != $past(retired_cnt)) |-> $past(b_valid && b_ready));

endmodule

bind wresp_order_tracker wresp_order_tracker_sva #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
) sva_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .aw_valid        (aw_valid),
    .aw_ready        (aw_ready),
    .b_valid         (b_valid),
    .b_ready         (b_ready),
    .err_id_mismatch (err_id_mismatch),
    .err_timeout     (err_timeout),
    .err_unexpected  (err_unexpected),
    .occupancy       (occupancy),
    .empty           (empty),
    .retired_cnt     (retired_cnt)
);

// File: tb/wresp_order_tracker_tb_top.sv
module wresp_order_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 4;
    localparam int ID_W       = 4;
    localparam int TO         = 8;
    localparam int CNT_W      = 16;
    localparam int OCC_W      = $clog2(SLOTS + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
    logic [ID_W-1:0] aw_id, b_id;

    logic             e1_mis, e1_early, e1_to, e1_ovf, e1_unexp, e1_empty;
    logic [OCC_W-1:0] e1_occ;
    logic [CNT_W-1:0] e1_push, e1_ret;
    logic             e2_mis, e2_early, e2_to, e2_ovf, e2_unexp, e2_empty;
    logic [OCC_W-1:0] e2_occ;
    logic [CNT_W-1:0] e2_push, e2_ret;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wresp_order_tracker #(.SLOTS(SLOTS), .ID_W(ID_W), .TIMEOUT(TO), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
        .err_id_mismatch(e1_mis), .err_early_resp(e1_early), .err_timeout(e1_to),
        .err_overflow(e1_ovf), .err_unexpected(e1_unexp),
        .occupancy(e1_occ), .empty(e1_empty), .pushed_cnt(e1_push), .retired_cnt(e1_ret));

    wresp_order_tracker #(.SLOTS(SLOTS), .ID_W(ID_W), .TIMEOUT(TO), .CNT_W(CNT_W),
                          .TIMEOUT_EN(1'b0), .OVERFLOW_EN(1'b0)) dut_nochk_i (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
        .err_id_mismatch(e2_mis), .err_early_resp(e2_early), .err_timeout(e2_to),
        .err_overflow(e2_ovf), .err_unexpected(e2_unexp),
        .occupancy(e2_occ), .empty(e2_empty), .pushed_cnt(e2_push), .retired_cnt(e2_ret));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference model
    int m_ids[$];
    int m_seq[$];
    int m_age[$];
    int m_pushes, m_lasts, m_pushed, m_retired;
    bit x_mis, x_early, x_to, x_ovf, x_unexp;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_ids.delete(); m_seq.delete(); m_age.delete();
        m_pushes = 0; m_lasts = 0; m_pushed = 0; m_retired = 0;
        x_mis = 0; x_early = 0; x_to = 0; x_ovf = 0; x_unexp = 0;
    endtask

    task automatic model_step(input bit awh, input int awid, input bit wlh, input bit bh, input int bid);
        int  sz;
        bit  ret;
        sz = m_ids.size();
        ret = bh && (sz > 0);
        x_mis = 0; x_early = 0; x_to = 0; x_ovf = 0; x_unexp = 0;
        if (bh && sz == 0) x_unexp = 1;
        if (ret) begin
            if (bid != m_ids[0]) x_mis = 1;
            if (!(m_seq[0] < m_lasts)) x_early = 1;
            void'(m_ids.pop_front()); void'(m_seq.pop_front()); void'(m_age.pop_front());
            m_retired++;
        end
        foreach (m_age[i]) begin
            if (m_age[i] == TO - 1) x_to = 1;
            if (m_age[i] < TO) m_age[i]++;
        end
        if (awh) begin
            if (sz == SLOTS && !ret) x_ovf = 1;
            else begin
                m_ids.push_back(awid); m_seq.push_back(m_pushes); m_age.push_back(0);
                m_pushes++; m_pushed++;
            end
        end
        if (wlh) m_lasts++;
    endtask

    task automatic compare_all();
        chk("R3", "err_id_mismatch", int'(e1_mis), int'(x_mis));
        chk("R4", "err_early_resp", int'(e1_early), int'(x_early));
        chk("R5", "err_timeout", int'(e1_to), int'(x_to));
        chk("R6", "err_overflow", int'(e1_ovf), int'(x_ovf));
        chk("R7", "err_unexpected", int'(e1_unexp), int'(x_unexp));
        chk("R2", "occupancy", int'(e1_occ), m_ids.size());
        chk("R9", "empty", int'(e1_empty), int'(m_ids.size() == 0));
        chk("R2", "pushed_cnt", int'(e1_push), m_pushed);
        chk("R9", "retired_cnt", int'(e1_ret), m_retired);
        chk("R5", "timeout disabled", int'(e2_to), 0);
        chk("R6", "overflow disabled", int'(e2_ovf), 0);
        chk("R6", "occupancy without flag", int'(e2_occ), m_ids.size());
        chk("R3", "mismatch without optional checks", int'(e2_mis), int'(x_mis));
    endtask

    // drive one cycle, step model, compare one register stage later
    task automatic step(input bit awv, input bit awr, input int awid,
                        input bit wv, input bit wr, input bit wl,
                        input bit bv, input bit br, input int bid);
        aw_valid = awv; aw_ready = awr; aw_id = ID_W'(awid);
        w_valid = wv; w_ready = wr; w_last = wl;
        b_valid = bv; b_ready = br; b_id = ID_W'(bid);
        model_step(awv && awr, awid, wv && wr && wl, bv && br, bid);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        aw_valid = 0; aw_ready = 0; aw_id = '0; w_valid = 0; w_ready = 0; w_last = 0;
        b_valid = 0; b_ready = 0; b_id = '0;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "occupancy in reset", int'(e1_occ), 0);
        chk("R1", "empty in reset", int'(e1_empty), 1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "occupancy after reset", int'(e1_occ), 0);
        chk("R1", "pushed after reset", int'(e1_push), 0);
        chk("R1", "retired after reset", int'(e1_ret), 0);
        chk("R1", "errors after reset",
            int'({e1_mis, e1_early, e1_to, e1_ovf, e1_unexp}), 0);
        chk("R1", "empty after reset", int'(e1_empty), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R2: valid without ready is ignored
        step(1, 0, 9, 0, 0, 0, 0, 0, 0);
        chk("R2", "aw valid without ready", int'(e1_occ), 0);

        // single write: two beats then response
        step(1, 1, 3, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 3);
        chk("R3", "matching response clean", int'(e1_mis), 0);

        // pipeline of four, R10 head advances
        step(1, 1, 1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 2, 1, 1, 1, 0, 0, 0);
        step(1, 1, 4, 1, 1, 1, 0, 0, 0);
        step(1, 1, 7, 1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 1, 1, 2);
        chk("R10", "second response against next id", int'(e1_mis), 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 9);
        chk("R3", "wrong id flagged", int'(e1_mis), 1);
        step(0, 0, 0, 0, 0, 0, 1, 1, 7);

        // R7: response with nothing outstanding
        step(0, 0, 0, 0, 0, 0, 1, 1, 5);
        chk("R7", "unexpected response", int'(e1_unexp), 1);

        // R4: data before address
        step(0, 0, 0, 1, 1, 1, 0, 0, 0);
        step(1, 1, 6, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 6);
        chk("R4", "data before address not early", int'(e1_early), 0);

        // R6/R8: fill, overflow, simultaneous push and retire
        step(1, 1, 1, 1, 1, 1, 0, 0, 0);
        step(1, 1, 2, 1, 1, 1, 0, 0, 0);
        step(1, 1, 3, 1, 1, 1, 0, 0, 0);
        step(1, 1, 4, 1, 1, 1, 0, 0, 0);
        step(1, 1, 5, 0, 0, 0, 0, 0, 0);
        chk("R6", "overflow flagged", int'(e1_ovf), 1);
        step(1, 1, 8, 1, 1, 1, 1, 1, 1);
        chk("R8", "full push plus retire", int'(e1_occ), 4);
        chk("R8", "no overflow on net zero", int'(e1_ovf), 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 2);
        step(0, 0, 0, 0, 0, 0, 1, 1, 3);
        step(0, 0, 0, 0, 0, 0, 1, 1, 4);
        step(0, 0, 0, 0, 0, 0, 1, 1, 8);
        chk("R9", "drained empty", int'(e1_empty), 1);

        // R5: stalled write
        step(1, 1, 2, 0, 0, 0, 0, 0, 0);
        idle(TO + 2);
        step(0, 0, 0, 1, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 2);

        // R4: response before final beat
        step(1, 1, 5, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, 5);
        chk("R4", "premature response", int'(e1_early), 1);

        do_reset();
        step(1, 1, 11, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 1, 1, 1, 11);
        chk("R4", "last in same cycle is late", int'(e1_early), 1);
        idle(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule